// File: doc/BRIEF.md
# Century Rollover Detector with Sleep-Aware Interrupt Gating

This block keeps a copy of a real-time clock's BCD year register and looks for the year wrapping from 99 to 00. Two sources can change the year. One is a host register write port, which is decoded by register index. The other is the update strobe from the time-keeping counter. Whenever the stored year goes from 99 to 00, the block sets a sticky status flag. Firmware can read that flag at any later time, including after a resume from sleep.

The same rollover also raises a one-cycle system-management interrupt request. This happens only when the power state input reports the fully running state. In every sleep state, and in the unused state codes, the rollover records the flag alone. A handler, or firmware after wake-up, clears the flag by writing a one to its bit in the status byte. Counting time, storing the century and routing the interrupt are handled elsewhere.

Top module: `century_wrap_detector`

## Requirements
- R1: After a synchronous active-low reset, `year_q` is 8'h00, `sts_q` is 8'h00 and `smi_req` is 0.
- R2: A host write with `host_wr_idx` equal to 8'h09 loads `host_wr_data` into `year_q` one clock later. Host writes to any other index leave `year_q` unchanged.
- R3: When `tick_upd_en` is high, `tick_year` is loaded into `year_q` one clock later. If a host year write occurs in the same cycle, the host data wins.
- R4: A load that changes the stored year from BCD 8'h99 to 8'h00 sets bit 7 of `sts_q` one clock later. This applies to both sources. All other bits of `sts_q` always read 0.
- R5: On such a rollover with `pwr_state` equal to 3'd0 (running), `smi_req` is high for exactly the one cycle in which the status bit first shows the rollover.
- R6: On a rollover with `pwr_state` at any value from 3'd1 to 3'd7 (sleep states and unused codes), the status bit is set and `smi_req` stays 0.
- R7: A load of 8'h00 when the stored year is not 8'h99 does not set the status bit. A load of any value other than 8'h00 when the stored year is 8'h99 does not set it either. A host write of 8'h00 to an index other than 8'h09 does not set it.
- R8: The status bit stays set until a status write with `sts_wr_data[7]` equal to 1 clears it one clock later. A status write with bit 7 equal to 0 has no effect.
- R9: If a rollover and a clearing status write occur in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_idx | input | 8 | Host register index (year is 8'h09) |
| host_wr_data | input | 8 | Host write data (BCD) |
| tick_upd_en | input | 1 | Year update strobe from the time-keeping counter |
| tick_year | input | 8 | Year value from the time-keeping counter (BCD) |
| pwr_state | input | 3 | Power state: 0 running, 1..5 sleep states |
| sts_wr_en | input | 1 | Status byte write strobe |
| sts_wr_data | input | 8 | Status write data; bit 7 written 1 clears the flag |
| year_q | output | 8 | Stored year |
| sts_q | output | 8 | Status byte; bit 7 is the rollover flag |
| smi_req | output | 1 | One-cycle interrupt request |

## Verification
Every result of this block appears exactly one clock after the stimulus that causes it. This covers the year load, the setting or clearing of the flag, and the interrupt pulse, because each output comes straight from a single register. The driver applies one stimulus per cycle on the falling edge. It then queues the expected year, status byte and interrupt level for the next rising edge. The monitor samples shortly after that rising edge and compares against the head of the queue. Idle cycles are queued as well, which lets the bench confirm that the interrupt pulse falls after one cycle and that the flag holds.

// File: rtl/cwd_pkg.sv
// Package: shared constants for the century rollover detector.
// Assumes BCD year coding and a 3-bit power state code where 0 is running.
package cwd_pkg;
    localparam int          CWD_YEAR_W    = 8;
    localparam int          CWD_IDX_W     = 8;
    localparam int          CWD_PS_W      = 3;
    localparam int          CWD_STS_W     = 8;
    localparam int          CWD_STS_BIT   = 7;
    localparam logic [7:0]  CWD_YEAR_IDX  = 8'h09;
    localparam logic [7:0]  CWD_WRAP_FROM = 8'h99;
    localparam logic [7:0]  CWD_WRAP_TO   = 8'h00;
    localparam logic [2:0]  CWD_PS_RUN    = 3'd0;

    // Source chosen for the next year load.
    typedef enum logic [1:0] {
        YSRC_HOLD = 2'd0,
        YSRC_HOST = 2'd1,
        YSRC_TICK = 2'd2
    } ysrc_e;
endpackage

// File: rtl/cwd_year_track.sv
// Module: cwd_year_track
// Holds the year value. Picks between the host write port and the counter update,
// with the host taking priority. Flags a wrap when a load moves the year from
// WRAP_FROM to WRAP_TO. Assumes both sources present complete BCD bytes.
module cwd_year_track
    import cwd_pkg::*;
#(
    parameter int               YEAR_W    = CWD_YEAR_W,
    parameter int               IDX_W     = CWD_IDX_W,
    parameter logic [IDX_W-1:0] YEAR_IDX  = CWD_YEAR_IDX,
    parameter logic [YEAR_W-1:0] WRAP_FROM = CWD_WRAP_FROM,
    parameter logic [YEAR_W-1:0] WRAP_TO   = CWD_WRAP_TO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [IDX_W-1:0]  host_wr_idx,
    input  logic [YEAR_W-1:0] host_wr_data,
    input  logic              tick_upd_en,
    input  logic [YEAR_W-1:0] tick_year,
    output logic [YEAR_W-1:0] year_q,
    output logic              wrap_evt
);
    ysrc_e             src;
    logic [YEAR_W-1:0] year_nxt;
    logic              host_hit;

    // Decode the host write against the year index.
    assign host_hit = host_wr_en && (host_wr_idx == YEAR_IDX);

    // Choose the load source: host first, then the counter.
    always_comb begin
        if (host_hit)         src = YSRC_HOST;
        else if (tick_upd_en) src = YSRC_TICK;
        else                  src = YSRC_HOLD;
    end

    // Form the value that the year register takes next.
    always_comb begin
        unique case (src)
            YSRC_HOST: year_nxt = host_wr_data;
            YSRC_TICK: year_nxt = tick_year;
            default:   year_nxt = year_q;
        endcase
    end

    // Detect a load that crosses from the last year of a century to the first.
    always_comb begin
        wrap_evt = (src != YSRC_HOLD) && (year_q == WRAP_FROM) && (year_nxt == WRAP_TO);
    end

    // Year register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) year_q <= '0;
        else        year_q <= year_nxt;
    end

    // R2
    host_year_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_idx == YEAR_IDX) |=> (year_q == $past(host_wr_data)));

    // R2
    host_other_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_idx != YEAR_IDX && !tick_upd_en) |=> $stable(year_q));

    // R3
    tick_year_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_upd_en && !(host_wr_en && host_wr_idx == YEAR_IDX)) |=> (year_q == $past(tick_year)));
endmodule

// File: rtl/cwd_sticky_flag.sv
// Module: cwd_sticky_flag
// A status byte in which one bit is a sticky flag that a set event raises and a
// write of 1 to that bit clears. Set wins over clear. All other bits read 0.
module cwd_sticky_flag #(
    parameter int STS_W   = cwd_pkg::CWD_STS_W,
    parameter int STS_BIT = cwd_pkg::CWD_STS_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_evt,
    input  logic             clr_wr_en,
    input  logic [STS_W-1:0] clr_wr_data,
    output logic [STS_W-1:0] sts_q
);
    logic flag_q;
    logic clr_hit;

    // A clear applies only when the flag's bit is written as 1.
    assign clr_hit = clr_wr_en && clr_wr_data[STS_BIT];

    // Flag register: set has priority, then write-1-to-clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_hit) flag_q <= 1'b0;
    end

    // Lay out the status byte: the flag sits at its bit, the rest read zero.
    for (genvar b = 0; b < STS_W; b++) begin : g_sts
        if (b == STS_BIT) begin : g_flag
            assign sts_q[b] = flag_q;
        end else begin : g_zero
            assign sts_q[b] = 1'b0;
        end
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> sts_q[STS_BIT]);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_en && clr_wr_data[STS_BIT] && !set_evt) |=> !sts_q[STS_BIT]);
endmodule

// File: rtl/cwd_smi_gate.sv
// Module: cwd_smi_gate
// Turns a wrap event into a one-cycle interrupt request, but only while the
// power state reports the running code. Assumes wrap events are single-cycle.
module cwd_smi_gate #(
    parameter int              PS_W   = cwd_pkg::CWD_PS_W,
    parameter logic [PS_W-1:0] PS_RUN = cwd_pkg::CWD_PS_RUN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wrap_evt,
    input  logic [PS_W-1:0] pwr_state,
    output logic            smi_req
);
    logic running;

    // Running only for the exact running code; every other code is treated as sleep.
    assign running = (pwr_state == PS_RUN);

    // Registered pulse: high for one cycle after a wrap seen in the running state.
    always_ff @(posedge clk) begin
        if (!rst_n) smi_req <= 1'b0;
        else        smi_req <= wrap_evt && running;
    end

    // R6
    no_smi_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != PS_RUN) |=> !smi_req);

    // R5
    smi_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req);
endmodule

// File: rtl/century_wrap_detector.sv
// Module: century_wrap_detector
// Top level. Tracks the BCD year, records a 99-to-00 rollover in a sticky status
// bit and issues an interrupt request only in the running power state.
// Assumes a single clock domain and synchronous active-low reset.
module century_wrap_detector
    import cwd_pkg::*;
#(
    parameter int                YEAR_W    = CWD_YEAR_W,
    parameter int                IDX_W     = CWD_IDX_W,
    parameter int                PS_W      = CWD_PS_W,
    parameter int                STS_W     = CWD_STS_W,
    parameter int                STS_BIT   = CWD_STS_BIT,
    parameter logic [IDX_W-1:0]  YEAR_IDX  = CWD_YEAR_IDX,
    parameter logic [YEAR_W-1:0] WRAP_FROM = CWD_WRAP_FROM,
    parameter logic [YEAR_W-1:0] WRAP_TO   = CWD_WRAP_TO,
    parameter logic [PS_W-1:0]   PS_RUN    = CWD_PS_RUN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [IDX_W-1:0]  host_wr_idx,
    input  logic [YEAR_W-1:0] host_wr_data,
    input  logic              tick_upd_en,
    input  logic [YEAR_W-1:0] tick_year,
    input  logic [PS_W-1:0]   pwr_state,
    input  logic              sts_wr_en,
    input  logic [STS_W-1:0]  sts_wr_data,
    output logic [YEAR_W-1:0] year_q,
    output logic [STS_W-1:0]  sts_q,
    output logic              smi_req
);
    logic wrap_evt;

    // Year storage and wrap detection.
    cwd_year_track #(
        .YEAR_W(YEAR_W), .IDX_W(IDX_W), .YEAR_IDX(YEAR_IDX),
        .WRAP_FROM(WRAP_FROM), .WRAP_TO(WRAP_TO)
    ) u_year (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx), .host_wr_data(host_wr_data),
        .tick_upd_en(tick_upd_en), .tick_year(tick_year),
        .year_q(year_q), .wrap_evt(wrap_evt)
    );

    // Sticky rollover flag in the status byte.
    cwd_sticky_flag #(.STS_W(STS_W), .STS_BIT(STS_BIT)) u_flag (
        .clk(clk), .rst_n(rst_n),
        .set_evt(wrap_evt), .clr_wr_en(sts_wr_en), .clr_wr_data(sts_wr_data),
        .sts_q(sts_q)
    );

    // Power-state gated interrupt request.
    cwd_smi_gate #(.PS_W(PS_W), .PS_RUN(PS_RUN)) u_smi (
        .clk(clk), .rst_n(rst_n),
        .wrap_evt(wrap_evt), .pwr_state(pwr_state),
        .smi_req(smi_req)
    );

    // R7
    rise_needs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[STS_BIT]) |-> ($past(year_q) == WRAP_FROM && year_q == WRAP_TO));

    // R5
    smi_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> sts_q[STS_BIT]);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[STS_BIT] && !(sts_wr_en && sts_wr_data[STS_BIT])) |=> sts_q[STS_BIT]);

    // R4
    other_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sts_q) == (sts_q[STS_BIT] ? 1 : 0));
endmodule

// File: tb/century_wrap_detector_tb.sv
// Scoreboard bench: the driver applies one stimulus per cycle and queues the
// expected outputs. The monitor compares them just after the next rising edge.
module century_wrap_detector_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_wr_idx = 8'h00;
    logic [7:0] host_wr_data = 8'h00;
    logic       tick_upd_en = 1'b0;
    logic [7:0] tick_year = 8'h00;
    logic [2:0] pwr_state = 3'd0;
    logic       sts_wr_en = 1'b0;
    logic [7:0] sts_wr_data = 8'h00;
    logic [7:0] year_q;
    logic [7:0] sts_q;
    logic       smi_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] year;
        logic [7:0] sts;
        logic       smi;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    // Bench-side model of the stored year and the flag.
    logic [7:0] m_year = 8'h00;
    logic       m_flag = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    century_wrap_detector u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx), .host_wr_data(host_wr_data),
        .tick_upd_en(tick_upd_en), .tick_year(tick_year), .pwr_state(pwr_state),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
        .year_q(year_q), .sts_q(sts_q), .smi_req(smi_req)
    );

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus and queue what the next rising edge must produce.
    task automatic step(input logic hw, input logic [7:0] idx, input logic [7:0] hd,
                        input logic tu, input logic [7:0] ty, input logic [2:0] ps,
                        input logic cw, input logic [7:0] cd, input string tag);
        exp_t e;
        logic [7:0] ny;
        logic loads;
        logic wrap;
        @(negedge clk);
        host_wr_en = hw; host_wr_idx = idx; host_wr_data = hd;
        tick_upd_en = tu; tick_year = ty; pwr_state = ps;
        sts_wr_en = cw; sts_wr_data = cd;
        loads = (hw && idx == 8'h09) || tu;
        ny = (hw && idx == 8'h09) ? hd : (tu ? ty : m_year);
        wrap = loads && (m_year == 8'h99) && (ny == 8'h00);
        if (wrap) m_flag = 1'b1;
        else if (cw && cd[7]) m_flag = 1'b0;
        m_year = ny;
        e.year = m_year;
        e.sts = {m_flag, 7'b0};
        e.smi = wrap && (ps == 3'd0);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input logic [2:0] ps, input string tag);
        step(1'b0, 8'h00, 8'h00, 1'b0, 8'h00, ps, 1'b0, 8'h00, tag);
    endtask

    task automatic hwr(input logic [7:0] idx, input logic [7:0] d, input logic [2:0] ps, input string tag);
        step(1'b1, idx, d, 1'b0, 8'h00, ps, 1'b0, 8'h00, tag);
    endtask

    task automatic tick(input logic [7:0] y, input logic [2:0] ps, input string tag);
        step(1'b0, 8'h00, 8'h00, 1'b1, y, ps, 1'b0, 8'h00, tag);
    endtask

    task automatic clr(input logic [7:0] d, input string tag);
        step(1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 3'd0, 1'b1, d, tag);
    endtask

    // Monitor: compare just after each rising edge against the queued expectation.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check8(e.tag, "year_q", year_q, e.year);
            check8(e.tag, "sts_q", sts_q, e.sts);
            check8(e.tag, "smi_req", {7'b0, smi_req}, {7'b0, e.smi});
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check8("R1", "year_q", year_q, 8'h00);
        check8("R1", "sts_q", sts_q, 8'h00);
        check8("R1", "smi_req", {7'b0, smi_req}, 8'h00);
        rst_n = 1'b1;

        // R2: host write at year index, then at another index
        hwr(8'h09, 8'h45, 3'd0, "R2");
        hwr(8'h08, 8'h77, 3'd0, "R2");
        // R3: counter update, then both in one cycle (host wins)
        tick(8'h46, 3'd0, "R3");
        step(1'b1, 8'h09, 8'h12, 1'b1, 8'h13, 3'd0, 1'b0, 8'h00, "R3");
        // R4 R5: host rollover in running state
        hwr(8'h09, 8'h99, 3'd0, "R4");
        hwr(8'h09, 8'h00, 3'd0, "R5");
        idle(3'd0, "R5");
        // R8: clear with bit 7 low is ignored, then a real clear
        clr(8'h7F, "R8");
        idle(3'd0, "R8");
        clr(8'h80, "R8");
        // R7: non-rollover cases
        hwr(8'h09, 8'h98, 3'd0, "R7");
        hwr(8'h09, 8'h00, 3'd0, "R7");
        hwr(8'h09, 8'h00, 3'd0, "R7");
        hwr(8'h09, 8'h99, 3'd0, "R7");
        hwr(8'h09, 8'h01, 3'd0, "R7");
        hwr(8'h09, 8'h99, 3'd0, "R7");
        hwr(8'h0A, 8'h00, 3'd0, "R7");
        // R6: rollover through the counter in sleep states
        tick(8'h00, 3'd3, "R6");
        idle(3'd3, "R6");
        clr(8'hFF, "R6");
        tick(8'h99, 3'd5, "R6");
        tick(8'h00, 3'd5, "R6");
        clr(8'h80, "R6");
        tick(8'h99, 3'd7, "R6");
        tick(8'h00, 3'd7, "R6");
        clr(8'h80, "R6");
        // R4: counter rollover in the running state
        tick(8'h99, 3'd0, "R4");
        tick(8'h00, 3'd0, "R4");
        idle(3'd0, "R4");
        // R9: rollover together with a clear; set wins
        tick(8'h99, 3'd0, "R9");
        step(1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 3'd0, 1'b1, 8'h80, "R9");
        idle(3'd0, "R9");
        clr(8'h80, "R8");
        idle(3'd0, "R8");

        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule